// File: doc/BRIEF.md
# Multiphase Post-Oscillator Clock Divider

This block sits behind a fast oscillator and turns its clock into a family of related slower clocks. A free-running halving flop always gives half the oscillator rate. A shared tick counter then makes four main clocks at one quarter or one eighth of the oscillator rate, plus a double-rate clock and a half-rate clock that are both aligned to main clock 0. A two-bit phase select fixes how the four main clocks are shifted against each other. Two active-low enables, one per output group, switch outputs on and off without ever cutting a pulse short.

In test mode the oscillator no longer advances the counter. Each level change of an external reference advances it by one tick instead, so the reference enters behind the first halving stage. The main clocks then run at half the reference rate in divide-by-four mode and a quarter of it in divide-by-eight mode. All clocks are produced in one synchronous domain, which is the oscillator clock. Mode and phase selects are meant to be static while the block runs. Changing them is done under reset.

A start-up sequencer has two states. `SEQ_HOLD` keeps the tick counter at zero for `SYNC_STAGES+1` cycles after reset so that the enable synchronisers can fill. The transition HOLD→RUN follows when that count ends, and `SEQ_RUN` then lets the counter advance. Each gated output has its own two-state gate FSM. The transition OFF→ON happens when the synchronised enable is set and the ungated clock is low. The transition ON→OFF happens when the enable is clear and the ungated clock is low.

Top module: `mphase_clk_divider`

## Requirements
- R1: With `div8_i`=0 and test mode off, each main clock has a period of 4 oscillator cycles and a high time of 2 cycles.
- R2: With `div8_i`=1 and test mode off, each main clock has a period of 8 oscillator cycles and a high time of 4 cycles.
- R3: `osc_half_o` toggles on every oscillator cycle after reset, whatever the mode, test or enable inputs are.
- R4: With `test_mode_i`=1, only level changes of `ref_clk_i` advance the divider, one tick per change. A main clock period is then 2 reference periods with `div8_i`=0 and 4 reference periods with `div8_i`=1.
- R5: With `div8_i`=0, `dbl_clk_o` equals `main_clk_o[0]` on every cycle. With `div8_i`=1, it has half the period of `main_clk_o[0]`, and its rising edges include every rising edge of `main_clk_o[0]`.
- R6: `half_clk_o` has twice the period of `main_clk_o[0]`, and each of its rising edges falls in the same cycle as a rising edge of `main_clk_o[0]`.
- R7: `phase_sel_i` sets how far `main_clk_o[k]` lags `main_clk_o[0]`, in quarter periods for k=1,2,3. The code 00 gives 0,0,0. The code 01 gives 1,2,3. The code 10 gives 0,2,2. The code 11 gives 1,0,1.
- R8: While `grp_a_en_ni` is 1, `dbl_clk_o` and `half_clk_o` are held low.
- R9: While `grp_b_en_ni` is 1, all four main clocks are held low.
- R10: An enable change takes effect only while the affected ungated clock is low, so every high pulse on a gated output has its full width.
- R11: All outputs are low during reset and on the first cycle after it. `main_clk_o[0]` and `half_clk_o` make their first rising edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator clock; the only clock domain |
| rst_ni | input | 1 | Active-low asynchronous reset of all divider state |
| test_mode_i | input | 1 | 1: reference level changes advance the divider instead of the oscillator |
| ref_clk_i | input | 1 | External test reference, synchronised internally |
| div8_i | input | 1 | 0: main clocks at oscillator/4; 1: at oscillator/8 |
| phase_sel_i | input | 2 | Phase arrangement of the four main clocks (see R7) |
| grp_a_en_ni | input | 1 | Active-low enable for the double-rate and half-rate clocks |
| grp_b_en_ni | input | 1 | Active-low enable for the four main clocks |
| main_clk_o | output | 4 | Four main divided clocks |
| dbl_clk_o | output | 1 | Double-rate clock aligned to main clock 0 |
| half_clk_o | output | 1 | Half-rate clock aligned to main clock 0 |
| osc_half_o | output | 1 | Oscillator divided by two |

## Verification
Some results lag their cause. The counter starts `SYNC_STAGES+1` cycles after reset release. An enable change needs `SYNC_STAGES` cycles plus the wait for a low phase. In test mode a reference edge advances the divider `SYNC_STAGES+1` cycles after it occurs. The bench never checks against one fixed cycle. After each reset it waits four full main periods, and a queued expectation then describes a window of whole periods. The monitor measures that window at the falling edge: rising-edge counts, the width of every complete high pulse, and the lag between first rising edges modulo the period. These quantities do not depend on the fixed latencies.

// File: rtl/mphase_clk_pkg.sv
package mphase_clk_pkg;

    localparam int NUM_MAIN = 4;
    localparam int POS_W    = 4;

    typedef enum logic [1:0] {
        PH_ALIGNED  = 2'b00,
        PH_QUAD     = 2'b01,
        PH_SPLIT    = 2'b10,
        PH_QUAD_INV = 2'b11
    } phase_sel_e;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

    typedef enum logic {
        SEQ_HOLD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Lag of main output idx behind output 0, in quarter periods.
    function automatic logic [1:0] quarter_lag(phase_sel_e sel, int idx);
        logic [1:0] k;
        k = 2'(idx);
        unique case (sel)
            PH_ALIGNED:  return 2'd0;
            PH_QUAD:     return k;
            PH_SPLIT:    return (k >= 2'd2) ? 2'd2 : 2'd0;
            PH_QUAD_INV: return k + ((k >= 2'd2) ? 2'd2 : 2'd0);
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/mphase_step_src.sv
module mphase_step_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic test_en_i,
    input  logic ref_i,
    output logic step_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] ref_sh;
    logic            ref_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_sh <= '0;
        else        ref_sh <= {ref_sh[SH_W-2:0], ref_i};
    end

    // Any level change of the synchronised reference is one tick.
    assign ref_edge = ref_sh[SH_W-1] ^ ref_sh[SH_W-2];
    assign step_o   = run_i & (test_en_i ? ref_edge : 1'b1);

endmodule

// File: rtl/mphase_tick_counter.sv
module mphase_tick_counter
    import mphase_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [POS_W-1:0] pos_o,
    output logic             osc_half_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_o      <= '0;
            osc_half_o <= 1'b0;
        end else begin
            osc_half_o <= ~osc_half_o;
            if (step_i) pos_o <= pos_o + 1'b1;
        end
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> pos_o == $past(pos_o) + 1'b1);

    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pos_o));

endmodule

// File: rtl/mphase_phase_map.sv
module mphase_phase_map
    import mphase_clk_pkg::*;
(
    input  logic                div8_i,
    input  phase_sel_e          sel_i,
    input  logic [POS_W-1:0]    pos_i,
    output logic [NUM_MAIN-1:0] main_raw_o,
    output logic                dbl_raw_o,
    output logic                half_raw_o
);
    logic [POS_W-1:0] pos_p2;
    logic [POS_W-1:0] pos_p4;

    assign pos_p2 = pos_i + POS_W'(2);
    assign pos_p4 = pos_i + POS_W'(4);

    for (genvar k = 0; k < NUM_MAIN; k++) begin : g_main
        logic [1:0]       lag_q;
        logic [2:0]       lag_ticks;
        logic [POS_W-1:0] shifted;
        always_comb begin
            lag_q     = quarter_lag(sel_i, k);
            lag_ticks = div8_i ? {lag_q, 1'b0} : {1'b0, lag_q};
            shifted   = pos_i - POS_W'(lag_ticks);
            main_raw_o[k] = div8_i ? shifted[2] : shifted[1];
        end
    end

    // Rising edges of these land on rising edges of main output 0.
    assign dbl_raw_o  = div8_i ? pos_p2[1] : pos_i[1];
    assign half_raw_o = div8_i ? pos_p4[3] : pos_p2[2];

endmodule

// File: rtl/mphase_out_gate.sv
module mphase_out_gate
    import mphase_clk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic en_i,
    output logic out_o
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: if (en_i && !raw_i)  state_d = GATE_ON;
            GATE_ON:  if (!en_i && !raw_i) state_d = GATE_OFF;
            default:  state_d = GATE_OFF;
        endcase
    end

    always_comb begin
        out_o = raw_i && (state_q == GATE_ON);
    end

    // R10: a gated output only rises together with its source.
    p_full_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_o) |-> $rose(raw_i));

    // R9 and R8: a disable seen while low keeps the output low next cycle.
    p_off_stays_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !raw_i) |=> !out_o);

endmodule

// File: rtl/mphase_clk_divider.sv
module mphase_clk_divider
    import mphase_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_osc_i,
    input  logic                rst_ni,
    input  logic                test_mode_i,
    input  logic                ref_clk_i,
    input  logic                div8_i,
    input  logic [1:0]          phase_sel_i,
    input  logic                grp_a_en_ni,
    input  logic                grp_b_en_ni,
    output logic [NUM_MAIN-1:0] main_clk_o,
    output logic                dbl_clk_o,
    output logic                half_clk_o,
    output logic                osc_half_o
);
    localparam int HOLD_CYCLES = SYNC_STAGES + 1;
    localparam int HOLD_W      = $clog2(HOLD_CYCLES + 1);
    localparam int NUM_GATED   = NUM_MAIN + 2;

    seq_state_e          seq_q, seq_d;
    logic [HOLD_W-1:0]   hold_cnt;
    logic                run;
    logic                step;
    logic [POS_W-1:0]    pos;
    logic [NUM_MAIN-1:0] main_raw;
    logic                dbl_raw, half_raw;
    logic [SYNC_STAGES-1:0] en_a_sync, en_b_sync;
    logic [NUM_GATED-1:0] gated_raw, gated_en, gated_out;

    // Start-up sequencer: state register
    always_ff @(posedge clk_osc_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q    <= SEQ_HOLD;
            hold_cnt <= '0;
        end else begin
            seq_q <= seq_d;
            if (seq_q == SEQ_HOLD) hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Start-up sequencer: next state
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SEQ_HOLD: if (hold_cnt == HOLD_W'(HOLD_CYCLES - 1)) seq_d = SEQ_RUN;
            SEQ_RUN:  seq_d = SEQ_RUN;
            default:  seq_d = SEQ_HOLD;
        endcase
    end

    // Start-up sequencer: outputs
    always_comb begin
        run = (seq_q == SEQ_RUN);
    end

    // Enable synchronisers, reset to the disabled level
    always_ff @(posedge clk_osc_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_a_sync <= '0;
            en_b_sync <= '0;
        end else begin
            en_a_sync <= {en_a_sync[SYNC_STAGES-2:0], ~grp_a_en_ni};
            en_b_sync <= {en_b_sync[SYNC_STAGES-2:0], ~grp_b_en_ni};
        end
    end

    mphase_step_src #(.SYNC_STAGES(SYNC_STAGES)) u_step (
        .clk       (clk_osc_i),
        .rst_n     (rst_ni),
        .run_i     (run),
        .test_en_i (test_mode_i),
        .ref_i     (ref_clk_i),
        .step_o    (step)
    );

    mphase_tick_counter u_cnt (
        .clk        (clk_osc_i),
        .rst_n      (rst_ni),
        .step_i     (step),
        .pos_o      (pos),
        .osc_half_o (osc_half_o)
    );

    mphase_phase_map u_map (
        .div8_i     (div8_i),
        .sel_i      (phase_sel_e'(phase_sel_i)),
        .pos_i      (pos),
        .main_raw_o (main_raw),
        .dbl_raw_o  (dbl_raw),
        .half_raw_o (half_raw)
    );

    assign gated_raw = {half_raw, dbl_raw, main_raw};

    for (genvar g = 0; g < NUM_GATED; g++) begin : g_gate
        if (g < NUM_MAIN) begin : g_grp_b
            assign gated_en[g] = en_b_sync[SYNC_STAGES-1];
        end else begin : g_grp_a
            assign gated_en[g] = en_a_sync[SYNC_STAGES-1];
        end
        mphase_out_gate u_gate (
            .clk   (clk_osc_i),
            .rst_n (rst_ni),
            .raw_i (gated_raw[g]),
            .en_i  (gated_en[g]),
            .out_o (gated_out[g])
        );
    end

    assign main_clk_o = gated_out[NUM_MAIN-1:0];
    assign dbl_clk_o  = gated_out[NUM_MAIN];
    assign half_clk_o = gated_out[NUM_MAIN+1];

    p_hosc_toggle_r3: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
        1'b1 |=> osc_half_o != $past(osc_half_o));

    p_quiet_hold_r11: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
        (seq_q == SEQ_HOLD) |-> (main_clk_o == '0 && !dbl_clk_o && !half_clk_o));

endmodule

// File: tb/mphase_clk_divider_tb.sv
module mphase_clk_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_mode = 1'b0;
    logic       ref_clk = 1'b0;
    logic       div8 = 1'b0;
    logic [1:0] psel = 2'b00;
    logic       en_a_n = 1'b0;
    logic       en_b_n = 1'b0;
    logic [3:0] main_clk;
    logic       dbl_clk, half_clk, osc_half;

    int n_checks = 0;
    int n_fail   = 0;
    int n_pushed = 0;
    int n_done   = 0;
    bit finished = 1'b0;

    typedef struct {
        string name;
        int    win;
        int    p0;
        bit    d8;
        bit    chk_counts;
        int    rises[7];
        int    width[7];
        int    lag[4];
        string rreq[7];
    } exp_t;

    exp_t sb[$];

    mphase_clk_divider u_dut (
        .clk_osc_i   (clk),
        .rst_ni      (rst_n),
        .test_mode_i (test_mode),
        .ref_clk_i   (ref_clk),
        .div8_i      (div8),
        .phase_sel_i (psel),
        .grp_a_en_ni (en_a_n),
        .grp_b_en_ni (en_b_n),
        .main_clk_o  (main_clk),
        .dbl_clk_o   (dbl_clk),
        .half_clk_o  (half_clk),
        .osc_half_o  (osc_half)
    );

    initial forever #4 clk = ~clk;
    initial begin
        #3;
        forever #32 ref_clk = ~ref_clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic bit out_bit(int o);
        case (o)
            0, 1, 2, 3: return main_clk[o];
            4:          return dbl_clk;
            5:          return half_clk;
            default:    return osc_half;
        endcase
    endfunction

    function automatic int lag_quarters(int ps, int k);
        case (ps)
            0:       return 0;
            1:       return k;
            2:       return (k >= 2) ? 2 : 0;
            default: return k % 2;
        endcase
    endfunction

    function automatic int pmod(int a, int m);
        return ((a % m) + m) % m;
    endfunction

    // Driver: configure, reset, settle, push expectation, wait for the monitor.
    task automatic run_cfg(input bit d8, input int ps, input bit tst,
                           input bit ena, input bit enb, input bit toggle,
                           input string name);
        exp_t e;
        int tick;
        tick = tst ? 4 : 1;
        @(negedge clk);
        rst_n = 1'b0;
        div8 = d8; psel = 2'(ps); test_mode = tst;
        en_a_n = !ena; en_b_n = !enb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e.name = name;
        e.d8 = d8;
        e.p0 = (d8 ? 8 : 4) * tick;
        e.win = 64 * tick;
        e.chk_counts = !toggle;
        for (int k = 0; k < 4; k++) begin
            e.rises[k] = enb ? e.win / e.p0 : 0;
            e.width[k] = e.p0 / 2;
            e.lag[k]   = lag_quarters(ps, k) * e.p0 / 4;
            e.rreq[k]  = !enb ? "R9" : (tst ? "R4" : (d8 ? "R2" : "R1"));
        end
        e.rises[4] = ena ? (d8 ? 2 * e.win / e.p0 : e.win / e.p0) : 0;
        e.width[4] = d8 ? e.p0 / 4 : e.p0 / 2;
        e.rreq[4]  = ena ? "R5" : "R8";
        e.rises[5] = ena ? e.win / (2 * e.p0) : 0;
        e.width[5] = e.p0;
        e.rreq[5]  = ena ? "R6" : "R8";
        e.rises[6] = e.win / 2;
        e.width[6] = 1;
        e.rreq[6]  = "R3";
        repeat (4 * e.p0 + 8) @(negedge clk);
        sb.push_back(e);
        n_pushed++;
        if (toggle) begin
            // R10: switch both groups off and on again during the window.
            repeat (e.win / 4 + 1) @(negedge clk);
            en_a_n = 1'b1; en_b_n = 1'b1;
            repeat (e.win / 4 + 3) @(negedge clk);
            en_a_n = 1'b0; en_b_n = 1'b0;
        end
        wait (n_done == n_pushed);
    endtask

    // Monitor: pop an expectation, measure a window, compare.
    initial forever begin
        exp_t e;
        bit   prev[7];
        bit   seen_low[7];
        int   rises[7], first[7], run_len[7], bad_w[7];
        int   x2_diff;
        wait (sb.size() > 0);
        e = sb.pop_front();
        @(negedge clk);
        for (int o = 0; o < 7; o++) begin
            prev[o] = out_bit(o);
            seen_low[o] = !prev[o];
            rises[o] = 0; first[o] = -1; run_len[o] = 0; bad_w[o] = 0;
        end
        x2_diff = 0;
        for (int i = 0; i < e.win; i++) begin
            @(negedge clk);
            if (dbl_clk != main_clk[0]) x2_diff++;
            for (int o = 0; o < 7; o++) begin
                bit cur;
                cur = out_bit(o);
                if (cur && !prev[o]) begin
                    rises[o]++;
                    if (first[o] < 0) first[o] = i;
                    run_len[o] = 1;
                end else if (cur) begin
                    run_len[o]++;
                end
                if (!cur && prev[o] && seen_low[o] && run_len[o] != e.width[o])
                    bad_w[o]++;
                if (!cur) seen_low[o] = 1'b1;
                prev[o] = cur;
            end
        end
        for (int o = 0; o < 7; o++) begin
            if (e.chk_counts)
                chk(rises[o] == e.rises[o], e.rreq[o],
                    $sformatf("%s rising edges of output %0d", e.name, o),
                    rises[o], e.rises[o]);
            // R10: every complete high pulse has the full width.
            chk(bad_w[o] == 0, "R10",
                $sformatf("%s short or long pulses on output %0d", e.name, o),
                bad_w[o], 0);
        end
        if (e.chk_counts) begin
            for (int k = 1; k < 4; k++) begin
                if (first[0] >= 0 && first[k] >= 0)
                    chk(pmod(first[k] - first[0], e.p0) == e.lag[k], "R7",
                        $sformatf("%s lag of main %0d", e.name, k),
                        pmod(first[k] - first[0], e.p0), e.lag[k]);
            end
            if (first[0] >= 0 && first[5] >= 0)
                chk(pmod(first[5] - first[0], e.p0) == 0, "R6",
                    $sformatf("%s half-rate edge alignment", e.name),
                    pmod(first[5] - first[0], e.p0), 0);
            if (first[0] >= 0 && first[4] >= 0) begin
                if (e.d8)
                    chk(pmod(first[4] - first[0], e.p0 / 2) == 0, "R5",
                        $sformatf("%s double-rate edge alignment", e.name),
                        pmod(first[4] - first[0], e.p0 / 2), 0);
                else
                    chk(x2_diff == 0, "R5",
                        $sformatf("%s double-rate differs from main 0", e.name),
                        x2_diff, 0);
            end
        end
        n_done++;
    end

    // Reset behaviour (R11)
    task automatic reset_check();
        int f0, fh;
        @(negedge clk);
        rst_n = 1'b0; div8 = 1'b0; psel = 2'b00; test_mode = 1'b0;
        en_a_n = 1'b0; en_b_n = 1'b0;
        repeat (5) @(negedge clk);
        chk({main_clk, dbl_clk, half_clk, osc_half} == 7'b0, "R11",
            "outputs during reset", {main_clk, dbl_clk, half_clk, osc_half}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({main_clk, dbl_clk, half_clk} == 6'b0, "R11",
            "gated outputs on first cycle after reset",
            {main_clk, dbl_clk, half_clk}, 0);
        f0 = -1; fh = -1;
        for (int i = 0; i < 40; i++) begin
            if (f0 < 0 && main_clk[0]) f0 = i;
            if (fh < 0 && half_clk) fh = i;
            @(negedge clk);
        end
        chk(f0 >= 0 && f0 == fh, "R11", "first rise cycle of main 0 vs half-rate", f0, fh);
    endtask

    initial begin
        reset_check();
        run_cfg(0, 0, 0, 1, 1, 0, "div4 aligned");
        run_cfg(0, 1, 0, 1, 1, 0, "div4 quad");
        run_cfg(0, 2, 0, 1, 1, 0, "div4 split");
        run_cfg(0, 3, 0, 1, 1, 0, "div4 quad-inv");
        run_cfg(1, 0, 0, 1, 1, 0, "div8 aligned");
        run_cfg(1, 1, 0, 1, 1, 0, "div8 quad");
        run_cfg(1, 2, 0, 1, 1, 0, "div8 split");
        run_cfg(1, 3, 0, 1, 1, 0, "div8 quad-inv");
        run_cfg(0, 1, 1, 1, 1, 0, "test div4 quad");
        run_cfg(1, 2, 1, 1, 1, 0, "test div8 split");
        run_cfg(1, 3, 1, 1, 1, 0, "test div8 quad-inv");
        run_cfg(1, 1, 0, 0, 1, 0, "div8 group A off");
        run_cfg(0, 0, 0, 1, 0, 0, "div4 group B off");
        run_cfg(0, 1, 0, 1, 1, 1, "div4 enable toggling");
        run_cfg(1, 3, 1, 1, 1, 1, "test div8 enable toggling");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule